// File: doc/BRIEF.md
# System Chipset Control Register Bank

This block is the register bank of a system chipset. A host reaches it through a synchronous port with a byte address, 32-bit write data, a write strobe and a read strobe. Read data comes back one cycle after the strobe, together with a valid flag. The bank holds fixed-value and read/write configuration registers, each with a reset value. It also holds sixteen remote-speed slots, an interrupt enable mask, a latched view of the local-bus interrupt sources, and a sticky error-source register. Reading the error-source register clears it. A timer interrupt is set by an external tick and cleared by a read of an acknowledge location.

The bank also carries an I/O cache buffer window. It holds a maintenance register, a physical tag, a logical tag and a byte mask. When the logical tag and mask hold one fixed pattern, a write to the window becomes a single 32-bit memory write request. The request is offered on a valid/ready handshake. The host port reports busy until the request is taken, and any access made while busy is dropped. An access to an address that has no register reads as zero, changes nothing, and raises an error flag for one cycle.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, the configuration register (0x000) reads 0x410, the misc register (0x210) reads 0x18186 and the NVRAM protect register (0x220) reads 7. The revision register (0x008) always reads 1, and a write to it is ignored. The other three registers are read/write.
- R2: The remote-speed slots sit at 0x070 + 8*k for k = 0..15. Each slot is read/write. Slots 0..14 reset to 7 and slot 15 resets to 0.
- R3: The interrupt enable mask (0x228) is read/write and resets to 0x10. The source register (0x240) resets to 0, takes the value of lbus_src one cycle later, and ignores writes. lbus_irq is high while any bit is set in both the source register and the low 16 bits of the mask.
- R4: A read at 0x238 always returns 7. A write there is accepted, changes nothing and raises no error.
- R5: A read at the error-type location 0x208 returns 0.
- R6: A timer_tick pulse sets timer_irq from the next cycle on. A read at 0x230 returns 0 and clears timer_irq from the next cycle on.
- R7: Bits pulsed on nmi_set accumulate in the source register at 0x200. A read there returns the accumulated bits and clears them.
- R8: The maintenance (0x030), physical tag (0x048), logical tag (0x050) and byte mask (0x058) registers store written values and read them back. All reset to 0.
- R9: A window write (0x060) made while the logical tag is 0x80000001 and the byte mask is 0x0F0F0F0F raises mem_valid on the next cycle. The request carries mem_data equal to the write data and mem_addr = (physical tag with bit 0 cleared) + ((maintenance & 3) << 3).
- R10: A window write made under any other tag or mask value issues no request.
- R11: While a request is pending, mem_valid, mem_addr and mem_data hold steady until a cycle with mem_ready high. busy equals mem_valid. Reads and writes offered while busy have no effect and produce no rd_valid.
- R12: An access to any other address returns 0 on a read and changes nothing on a write. It raises addr_err for exactly the one cycle after the access.
- R13: rd_valid is high in the cycle after an accepted read, with the read value on rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| busy | output | 1 | Memory request pending; accesses are dropped |
| addr_err | output | 1 | One-cycle pulse after an unmapped access |
| timer_tick | input | 1 | Timer expiry pulse |
| timer_irq | output | 1 | Timer interrupt |
| nmi_set | input | 8 | Error-source set pulses |
| lbus_src | input | 16 | Local-bus interrupt source levels |
| lbus_irq | output | 1 | Masked local-bus interrupt |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory write request accepted |
| mem_addr | output | 32 | Memory write address |
| mem_data | output | 32 | Memory write data |

## Verification
The assertions assume the host never raises wr_en and rd_en in the same cycle. They also assume the memory side may hold mem_ready low for any number of cycles. The bench drives one strobe at a time, always on the falling edge. It holds mem_ready low across several cycles before granting a pending request, so the hold-steady check sees a real stall. It also offers a write during busy and confirms from a later read that the write was dropped.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    parameter int unsigned ADDR_W  = 12;
    parameter int unsigned DATA_W  = 32;
    parameter int unsigned SPEED_N = 16;
    parameter int unsigned NMI_W   = 8;
    parameter int unsigned LBUS_W  = 16;
    localparam int unsigned SPD_IW = $clog2(SPEED_N);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_CONFIG, SEL_REV, SEL_SPEED, SEL_MAINT, SEL_PTAG,
        SEL_LTAG, SEL_BMASK, SEL_WINDOW, SEL_NMI, SEL_ERRTYPE, SEL_MISC,
        SEL_NVPROT, SEL_IMR, SEL_TIMACK, SEL_EISA, SEL_ISR
    } sel_e;

    typedef struct packed {
        sel_e              sel;
        logic [SPD_IW-1:0] idx;
    } dec_t;

    localparam addr_t A_CONFIG   = addr_t'(12'h000);
    localparam addr_t A_REV      = addr_t'(12'h008);
    localparam addr_t A_MAINT    = addr_t'(12'h030);
    localparam addr_t A_PTAG     = addr_t'(12'h048);
    localparam addr_t A_LTAG     = addr_t'(12'h050);
    localparam addr_t A_BMASK    = addr_t'(12'h058);
    localparam addr_t A_WINDOW   = addr_t'(12'h060);
    localparam addr_t A_SPEED0   = addr_t'(12'h070);
    localparam addr_t A_SPEEDN   = A_SPEED0 + addr_t'(8 * (SPEED_N - 1));
    localparam addr_t A_NMI      = addr_t'(12'h200);
    localparam addr_t A_ERRTYPE  = addr_t'(12'h208);
    localparam addr_t A_MISC     = addr_t'(12'h210);
    localparam addr_t A_NVPROT   = addr_t'(12'h220);
    localparam addr_t A_IMR      = addr_t'(12'h228);
    localparam addr_t A_TIMACK   = addr_t'(12'h230);
    localparam addr_t A_EISA     = addr_t'(12'h238);
    localparam addr_t A_ISR      = addr_t'(12'h240);

    localparam word_t CONFIG_RST = word_t'(32'h0000_0410);
    localparam word_t REV_VAL    = word_t'(32'h0000_0001);
    localparam word_t MISC_RST   = word_t'(32'h0001_8186);
    localparam word_t NVPROT_RST = word_t'(32'h0000_0007);
    localparam word_t IMR_RST    = word_t'(32'h0000_0010);
    localparam word_t SPEED_RST  = word_t'(32'h0000_0007);
    localparam word_t EISA_VAL   = word_t'(32'h0000_0007);
    localparam word_t WIN_LTAG   = word_t'(32'h8000_0001);
    localparam word_t WIN_BMASK  = word_t'(32'h0F0F_0F0F);

    function automatic dec_t decode_addr(addr_t a);
        dec_t d;
        d.sel = SEL_NONE;
        d.idx = '0;
        case (a)
            A_CONFIG:  d.sel = SEL_CONFIG;
            A_REV:     d.sel = SEL_REV;
            A_MAINT:   d.sel = SEL_MAINT;
            A_PTAG:    d.sel = SEL_PTAG;
            A_LTAG:    d.sel = SEL_LTAG;
            A_BMASK:   d.sel = SEL_BMASK;
            A_WINDOW:  d.sel = SEL_WINDOW;
            A_NMI:     d.sel = SEL_NMI;
            A_ERRTYPE: d.sel = SEL_ERRTYPE;
            A_MISC:    d.sel = SEL_MISC;
            A_NVPROT:  d.sel = SEL_NVPROT;
            A_IMR:     d.sel = SEL_IMR;
            A_TIMACK:  d.sel = SEL_TIMACK;
            A_EISA:    d.sel = SEL_EISA;
            A_ISR:     d.sel = SEL_ISR;
            default: begin
                if (a[2:0] == 3'b000 && a >= A_SPEED0 && a <= A_SPEEDN) begin
                    d.sel = SEL_SPEED;
                    d.idx = SPD_IW'((a - A_SPEED0) >> 3);
                end
            end
        endcase
        return d;
    endfunction

    function automatic word_t win_target(word_t ptag, logic [1:0] sub);
        return (ptag & ~word_t'(1)) + (word_t'(sub) << 3);
    endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  addr_t             addr,
    output sel_e              sel,
    output logic [SPD_IW-1:0] idx
);
    dec_t dec;
    assign dec = decode_addr(addr);
    assign sel = dec.sel;
    assign idx = dec.idx;
endmodule

// File: rtl/sysctl_speed_bank.sv
module sysctl_speed_bank
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SPD_IW-1:0] idx,
    input  word_t             wdata,
    output word_t             rdata
);
    word_t slot_rd [SPEED_N];

    for (genvar k = 0; k < SPEED_N; k++) begin : g_slot
        localparam word_t RV = (k < SPEED_N - 1) ? SPEED_RST : '0;
        word_t slot_q;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= RV;
            else if (we && idx == SPD_IW'(k))
                slot_q <= wdata;
        end
        assign slot_rd[k] = slot_q;
    end

    assign rdata = slot_rd[idx];
endmodule

// File: rtl/sysctl_win_req.sv
module sysctl_win_req
    import sysctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  win_wr,
    input  word_t ptag,
    input  word_t ltag,
    input  word_t bmask,
    input  word_t maint,
    input  word_t wdata,
    input  logic  mem_ready,
    output logic  mem_valid,
    output word_t mem_addr,
    output word_t mem_data
);
    logic hit;
    assign hit = win_wr && (ltag == WIN_LTAG) && (bmask == WIN_BMASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_valid <= 1'b0;
            mem_addr  <= '0;
            mem_data  <= '0;
        end else if (mem_valid) begin
            if (mem_ready)
                mem_valid <= 1'b0;
        end else if (hit) begin
            mem_valid <= 1'b1;
            mem_addr  <= win_target(ptag, maint[1:0]);
            mem_data  <= wdata;
        end
    end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              addr_err,
    input  logic              timer_tick,
    output logic              timer_irq,
    input  logic [NMI_W-1:0]  nmi_set,
    input  logic [LBUS_W-1:0] lbus_src,
    output logic              lbus_irq,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data
);
    sel_e              sel;
    logic [SPD_IW-1:0] sidx;
    logic              wr_go, rd_go;
    word_t             config_q, misc_q, nvprot_q, imr_q;
    word_t             maint_q, ptag_q, ltag_q, bmask_q;
    logic [NMI_W-1:0]  nmi_q;
    logic [LBUS_W-1:0] isr_q;
    word_t             spd_rd, rd_c;

    sysctl_decode u_dec (.addr(addr), .sel(sel), .idx(sidx));

    assign busy  = mem_valid;
    assign wr_go = wr_en & ~busy;
    assign rd_go = rd_en & ~wr_en & ~busy;

    sysctl_speed_bank u_spd (
        .clk(clk), .rst(rst), .we(wr_go && sel == SEL_SPEED),
        .idx(sidx), .wdata(wr_data), .rdata(spd_rd)
    );

    sysctl_win_req u_win (
        .clk(clk), .rst(rst), .win_wr(wr_go && sel == SEL_WINDOW),
        .ptag(ptag_q), .ltag(ltag_q), .bmask(bmask_q), .maint(maint_q),
        .wdata(wr_data), .mem_ready(mem_ready), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .mem_data(mem_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            config_q <= CONFIG_RST;
            misc_q   <= MISC_RST;
            nvprot_q <= NVPROT_RST;
            imr_q    <= IMR_RST;
            maint_q  <= '0;
            ptag_q   <= '0;
            ltag_q   <= '0;
            bmask_q  <= '0;
        end else if (wr_go) begin
            case (sel)
                SEL_CONFIG: config_q <= wr_data;
                SEL_MISC:   misc_q   <= wr_data;
                SEL_NVPROT: nvprot_q <= wr_data;
                SEL_IMR:    imr_q    <= wr_data;
                SEL_MAINT:  maint_q  <= wr_data;
                SEL_PTAG:   ptag_q   <= wr_data;
                SEL_LTAG:   ltag_q   <= wr_data;
                SEL_BMASK:  bmask_q  <= wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_irq <= 1'b0;
            nmi_q     <= '0;
            isr_q     <= '0;
        end else begin
            timer_irq <= timer_tick | (timer_irq & ~(rd_go && sel == SEL_TIMACK));
            nmi_q     <= nmi_set | ((rd_go && sel == SEL_NMI) ? '0 : nmi_q);
            isr_q     <= lbus_src;
        end
    end

    assign lbus_irq = |(isr_q & imr_q[LBUS_W-1:0]);

    always_comb begin
        case (sel)
            SEL_CONFIG: rd_c = config_q;
            SEL_REV:    rd_c = REV_VAL;
            SEL_SPEED:  rd_c = spd_rd;
            SEL_MAINT:  rd_c = maint_q;
            SEL_PTAG:   rd_c = ptag_q;
            SEL_LTAG:   rd_c = ltag_q;
            SEL_BMASK:  rd_c = bmask_q;
            SEL_NMI:    rd_c = word_t'(nmi_q);
            SEL_MISC:   rd_c = misc_q;
            SEL_NVPROT: rd_c = nvprot_q;
            SEL_IMR:    rd_c = imr_q;
            SEL_EISA:   rd_c = EISA_VAL;
            SEL_ISR:    rd_c = word_t'(isr_q);
            default:    rd_c = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            addr_err <= 1'b0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go)
                rd_data <= rd_c;
            addr_err <= (wr_go | rd_go) && sel == SEL_NONE;
        end
    end
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk
    import sysctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              busy,
    input logic              addr_err,
    input logic              timer_tick,
    input logic              timer_irq,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [DATA_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data
);
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    assert_busy_drop_R11: assert property (@(posedge clk) disable iff (rst)
        busy && rd_en |=> !rd_valid);

    assert_req_origin_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_valid) |-> $past(wr_en));

    assert_timer_origin_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(timer_irq) |-> $past(timer_tick));

    assert_rd_timing_R13: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en));

    assert_err_origin_R12: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> $past(wr_en || rd_en));

    assert_err_zero_R12: assert property (@(posedge clk) disable iff (rst)
        addr_err && rd_valid |-> rd_data == '0);
endmodule

bind sysctl_regs sysctl_regs_chk u_chk (.*);

// File: tb/test_sysctl_regs.sv
`timescale 1ns/1ps
module test_sysctl_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rd_valid, busy, addr_err;
    logic        timer_tick = 1'b0;
    logic        timer_irq;
    logic [7:0]  nmi_set = '0;
    logic [15:0] lbus_src = '0;
    logic        lbus_irq;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sysctl_regs i_sysctl_regs (.*);

    typedef struct packed {
        logic        wr;
        logic [11:0] a;
        logic [31:0] d;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 12'h000, 32'h0, 32'h0000_0410, 4'd1},  // R1 config reset
        '{1'b0, 12'h008, 32'h0, 32'h0000_0001, 4'd1},  // R1 revision
        '{1'b0, 12'h210, 32'h0, 32'h0001_8186, 4'd1},  // R1 misc reset
        '{1'b0, 12'h220, 32'h0, 32'h0000_0007, 4'd1},  // R1 nvram protect reset
        '{1'b0, 12'h070, 32'h0, 32'h0000_0007, 4'd2},  // R2 slot 0
        '{1'b0, 12'h0E0, 32'h0, 32'h0000_0007, 4'd2},  // R2 slot 14
        '{1'b0, 12'h0E8, 32'h0, 32'h0000_0000, 4'd2},  // R2 slot 15
        '{1'b0, 12'h228, 32'h0, 32'h0000_0010, 4'd3},  // R3 mask reset
        '{1'b0, 12'h240, 32'h0, 32'h0000_0000, 4'd3},  // R3 source reset
        '{1'b0, 12'h238, 32'h0, 32'h0000_0007, 4'd4},  // R4 fixed read
        '{1'b0, 12'h208, 32'h0, 32'h0000_0000, 4'd5},  // R5 error type
        '{1'b0, 12'h200, 32'h0, 32'h0000_0000, 4'd7},  // R7 source reset
        '{1'b1, 12'h000, 32'hABCD_1234, 32'h0, 4'd1},
        '{1'b0, 12'h000, 32'h0, 32'hABCD_1234, 4'd1},  // R1 config rw
        '{1'b1, 12'h008, 32'h0000_0005, 32'h0, 4'd1},
        '{1'b0, 12'h008, 32'h0, 32'h0000_0001, 4'd1},  // R1 revision write ignored
        '{1'b1, 12'h0E8, 32'h0000_0055, 32'h0, 4'd2},
        '{1'b1, 12'h078, 32'h0000_0033, 32'h0, 4'd2},
        '{1'b0, 12'h0E8, 32'h0, 32'h0000_0055, 4'd2},  // R2 slot 15 rw
        '{1'b0, 12'h078, 32'h0, 32'h0000_0033, 4'd2},  // R2 slot 1 rw
        '{1'b1, 12'h238, 32'h0000_0099, 32'h0, 4'd4},
        '{1'b0, 12'h238, 32'h0, 32'h0000_0007, 4'd4},  // R4 write ignored
        '{1'b1, 12'h030, 32'h0000_0006, 32'h0, 4'd8},
        '{1'b0, 12'h030, 32'h0, 32'h0000_0006, 4'd8},  // R8 maintenance
        '{1'b0, 12'h048, 32'h0, 32'h0000_0000, 4'd8},  // R8 tag reset
        '{1'b0, 12'h004, 32'h0, 32'h0000_0000, 4'd12}  // R12 unmapped read
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data; v = rd_valid;
    endtask

    task automatic finish_sim;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        logic [31:0] d;
        logic        v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset busy", {31'b0, busy}, 32'h0);
        check("R6 reset timer_irq", {31'b0, timer_irq}, 32'h0);
        check("R13 reset rd_valid", {31'b0, rd_valid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                wr(VEC[i].a, VEC[i].d);
            end else begin
                rd(VEC[i].a, d, v);
                check($sformatf("R%0d vec %0d", VEC[i].req, i), d, VEC[i].exp);
                check("R13 rd_valid", {31'b0, v}, 32'h1);
            end
        end

        // R12 unmapped write: one-cycle error pulse, nothing changed
        @(negedge clk); addr = 12'h0EC; wr_data = 32'hFFFF_FFFF; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        check("R12 err pulse", {31'b0, addr_err}, 32'h1);
        @(negedge clk);
        check("R12 err one cycle", {31'b0, addr_err}, 32'h0);
        rd(12'h0E8, d, v);
        check("R12 write ignored", d, 32'h55);
        // R4 write raises no error
        wr(12'h238, 32'h1);
        check("R4 no error", {31'b0, addr_err}, 32'h0);

        // R6 timer
        @(negedge clk); timer_tick = 1'b1;
        @(negedge clk); timer_tick = 1'b0;
        check("R6 tick sets", {31'b0, timer_irq}, 32'h1);
        rd(12'h230, d, v);
        check("R6 ack reads 0", d, 32'h0);
        check("R6 ack clears", {31'b0, timer_irq}, 32'h0);

        // R7 error-source accumulate and clear
        @(negedge clk); nmi_set = 8'h01;
        @(negedge clk); nmi_set = 8'h04;
        @(negedge clk); nmi_set = 8'h00;
        rd(12'h200, d, v);
        check("R7 accumulate", d, 32'h5);
        rd(12'h200, d, v);
        check("R7 clear on read", d, 32'h0);

        // R3 local-bus sources and mask
        @(negedge clk); lbus_src = 16'h0011;
        @(negedge clk);
        check("R3 lbus_irq masked", {31'b0, lbus_irq}, 32'h1);
        wr(12'h240, 32'h0);
        rd(12'h240, d, v);
        check("R3 source read only", d, 32'h11);
        wr(12'h228, 32'h0000_0002);
        check("R3 lbus_irq off", {31'b0, lbus_irq}, 32'h0);
        lbus_src = 16'h0000;

        // R10 window write without matching pattern
        wr(12'h048, 32'h0000_1235);
        wr(12'h050, 32'h8000_0001);
        wr(12'h058, 32'h0000_FFFF);
        wr(12'h060, 32'h1111_1111);
        check("R10 no request", {31'b0, mem_valid}, 32'h0);

        // R9 window write with matching pattern
        wr(12'h058, 32'h0F0F_0F0F);
        rd(12'h058, d, v);
        check("R8 mask rw", d, 32'h0F0F_0F0F);
        wr(12'h060, 32'hDEAD_BEEF);
        check("R9 request valid", {31'b0, mem_valid}, 32'h1);
        check("R9 request addr", mem_addr, 32'h0000_1244);
        check("R9 request data", mem_data, 32'hDEAD_BEEF);
        check("R11 busy", {31'b0, busy}, 32'h1);

        // R11 accesses during busy are dropped
        wr(12'h000, 32'h0000_0BAD);
        rd(12'h000, d, v);
        check("R11 read dropped", {31'b0, v}, 32'h0);
        check("R11 still valid", {31'b0, mem_valid}, 32'h1);
        check("R11 addr held", mem_addr, 32'h0000_1244);
        @(negedge clk); mem_ready = 1'b1;
        @(negedge clk); mem_ready = 1'b0;
        check("R11 accepted", {31'b0, mem_valid}, 32'h0);
        rd(12'h000, d, v);
        check("R11 write dropped", d, 32'hABCD_1234);

        // R9 second sub-index
        wr(12'h030, 32'h0000_0001);
        wr(12'h060, 32'h0000_0042);
        check("R9 sub-index addr", mem_addr, 32'h0000_123C);
        @(negedge clk); mem_ready = 1'b1;
        @(negedge clk); mem_ready = 1'b0;
        check("R11 released", {31'b0, busy}, 32'h0);

        // R1 reset restores values
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(12'h000, d, v);
        check("R1 reset again", d, 32'h0000_0410);

        finish_sim();
    end
endmodule